// File: doc/BRIEF.md
# Predicated Vector Floating-Point Minimum Against a Constant

This block is a one-stage vector datapath. It takes a packed vector of floating-point elements and a byte-granular predicate. For each active lane it returns the minimum number of the element and a small constant. A single select bit picks the constant: +0.0 or +1.0 in the lane's own format. Inactive lanes return their source bits untouched.

A 2-bit size code sets the lane format: half, single or double precision. The fourth code value is reserved and is flagged as illegal. A separate control bit decides how signaling NaNs are reported: either the NaN is quieted, or the format's default NaN is returned. Results are registered and appear one clock after the input strobe. The vector width is a parameter.

Quiet NaNs are not propagated. A lane holding a quiet NaN takes the constant as its result, as minimum-number semantics require. Ordering is exact sign-magnitude. Subnormals are never flushed, and negative zero ranks below positive zero.

Top module: `fpmin_imm_vec`

## Requirements
- R1: The size code selects the lane width: 2'b01 gives 16-bit lanes, 2'b10 gives 32-bit lanes and 2'b11 gives 64-bit lanes. Lane i occupies bits [i*EW +: EW] of the vector, and there are VW/EW lanes.
- R2: Size code 2'b00 is reserved. A strobe with this code raises `illegal` together with `out_valid`, and the result is all zeros.
- R3: A lane is active when predicate bit (i*EW/8) is 1. That bit is the lowest byte position of the lane; the other predicate bits inside the lane have no effect. An inactive lane returns its source bits unchanged.
- R4: The constant is +0.0 (all zeros) when `imm_one` is 0. When `imm_one` is 1 it is +1.0: 16'h3C00, 32'h3F800000 or 64'h3FF0000000000000, depending on the lane width.
- R5: For a non-NaN active element, the result is the smaller of the element and the constant under sign-magnitude ordering. Negative values, including -0.0 and -infinity, are below the constant. Subnormals are compared exactly. -0.0 against +0.0 returns -0.0.
- R6: An active lane holding a quiet NaN returns the constant. A quiet NaN has an all-ones exponent and the top fraction bit set.
- R7: An active lane holding a signaling NaN is handled according to `dn_mode`. A signaling NaN has an all-ones exponent, the top fraction bit clear and a nonzero fraction.
  - With `dn_mode`=0 the result is the same NaN with its top fraction bit set, keeping its sign and the rest of its payload.
  - With `dn_mode`=1 the result is the default NaN: 16'h7E00, 32'h7FC00000 or 64'h7FF8000000000000.
- R8: `out_valid`, `result` and `illegal` update on the clock edge that samples `in_valid`=1.
  - With `in_valid`=0, `out_valid` falls at the next edge and `result` holds its value.
  - Reset clears `out_valid`, `illegal` and `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Input strobe |
| size | input | 2 | Lane format code |
| imm_one | input | 1 | Constant select: 0 gives +0.0, 1 gives +1.0 |
| dn_mode | input | 1 | Signaling NaN reporting: 1 gives the default NaN |
| src | input | VW | Packed source vector |
| pred | input | VW/8 | Predicate, one bit per byte |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| illegal | output | 1 | Reserved size code was sampled |
| result | output | VW | Packed result vector |

## Verification
Any fault shows up at the ports in the first cycle after the strobe that exposes it, because the block holds no state beyond its output register.
- A wrong lane-activity decode shows up as a lane with a bad value. The lane is either altered when it should pass through, or passed through when it should hold the constant.
- A misplaced NaN test returns the constant where a quieted or default NaN is expected, or the reverse.
- A wrong zero-sign ordering shows up as the sign bit of a zero lane.
- A stale or dropped valid shows up as `out_valid` being high or low on the wrong edge, or as `result` changing while no strobe is given.

// File: rtl/fpmin_pkg.sv
package fpmin_pkg;
  typedef enum logic [1:0] {
    SZ_RSVD = 2'b00,
    SZ_HALF = 2'b01,
    SZ_SNGL = 2'b10,
    SZ_DBLE = 2'b11
  } lane_size_e;

  function automatic int frac_width(input int ew);
    return (ew == 16) ? 10 : (ew == 32) ? 23 : 52;
  endfunction
endpackage

// File: rtl/fpmin_lane.sv
module fpmin_lane
  import fpmin_pkg::*;
#(
  parameter int EW = 32
) (
  input  logic [EW-1:0] x,
  input  logic          imm_one,
  input  logic          dn_mode,
  output logic [EW-1:0] y
);
  localparam int FW = frac_width(EW);
  localparam int XW = EW - 1 - FW;

  localparam logic [EW-1:0] ONE_VAL  = {2'b00, {(XW-1){1'b1}}, {FW{1'b0}}};
  localparam logic [EW-1:0] DNAN_VAL = {1'b0, {XW{1'b1}}, 1'b1, {(FW-1){1'b0}}};
  localparam logic [EW-1:0] QBIT     = {{(XW+1){1'b0}}, 1'b1, {(FW-1){1'b0}}};

  logic [EW-1:0] cval;
  logic          exp_ones, frac_nz, is_nan, is_snan, x_less;

  always_comb begin
    cval     = imm_one ? ONE_VAL : '0;
    exp_ones = &x[EW-2:FW];
    frac_nz  = |x[FW-1:0];
    is_nan   = exp_ones && frac_nz;
    is_snan  = is_nan && !x[FW-1];
    // constant is never negative, so any negative element ranks below it
    x_less   = x[EW-1] || (x[EW-2:0] < cval[EW-2:0]);
    if (is_snan)      y = dn_mode ? DNAN_VAL : (x | QBIT);
    else if (is_nan)  y = cval;
    else if (x_less)  y = x;
    else              y = cval;
  end

  always_comb begin
    if (!$isunknown(y)) begin
      // R7
      no_snan_out_chk: assert (!((&y[EW-2:FW]) && (|y[FW-1:0]) && !y[FW-1]));
      // R5
      not_above_const_chk: assert (is_nan || y[EW-1] || (y[EW-2:0] <= cval[EW-2:0]));
    end
  end
endmodule

// File: rtl/fpmin_lane_array.sv
module fpmin_lane_array #(
  parameter int VW = 128,
  parameter int EW = 32
) (
  input  logic [VW-1:0]   src,
  input  logic [VW/8-1:0] pred,
  input  logic            imm_one,
  input  logic            dn_mode,
  output logic [VW-1:0]   res
);
  localparam int NL  = VW / EW;
  localparam int BPL = EW / 8;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic [EW-1:0] lane_out;
    logic          active;

    assign active = pred[l*BPL];

    fpmin_lane #(.EW(EW)) u_lane (
      .x      (src[l*EW +: EW]),
      .imm_one(imm_one),
      .dn_mode(dn_mode),
      .y      (lane_out)
    );

    assign res[l*EW +: EW] = active ? lane_out : src[l*EW +: EW];

    always_comb begin
      if (!$isunknown({active, res[l*EW +: EW], src[l*EW +: EW]})) begin
        // R3
        inactive_keep_chk: assert (active || (res[l*EW +: EW] == src[l*EW +: EW]));
      end
    end
  end
endmodule

// File: rtl/fpmin_imm_vec.sv
module fpmin_imm_vec
  import fpmin_pkg::*;
#(
  parameter int VW = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [1:0]      size,
  input  logic            imm_one,
  input  logic            dn_mode,
  input  logic [VW-1:0]   src,
  input  logic [VW/8-1:0] pred,
  output logic            out_valid,
  output logic            illegal,
  output logic [VW-1:0]   result
);
  localparam int PW = VW / 8;

  logic          rst_s1, rst_sn;
  logic [VW-1:0] res_h, res_s, res_d, res_nxt;
  logic          ill_nxt, vld_nxt;
  lane_size_e    sz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  fpmin_lane_array #(.VW(VW), .EW(16)) u_half (
    .src(src), .pred(pred), .imm_one(imm_one), .dn_mode(dn_mode), .res(res_h));
  fpmin_lane_array #(.VW(VW), .EW(32)) u_sngl (
    .src(src), .pred(pred), .imm_one(imm_one), .dn_mode(dn_mode), .res(res_s));
  fpmin_lane_array #(.VW(VW), .EW(64)) u_dble (
    .src(src), .pred(pred), .imm_one(imm_one), .dn_mode(dn_mode), .res(res_d));

  always_comb begin
    sz      = lane_size_e'(size);
    vld_nxt = in_valid;
    ill_nxt = illegal;
    res_nxt = result;
    if (in_valid) begin
      ill_nxt = 1'b0;
      unique case (sz)
        SZ_HALF: res_nxt = res_h;
        SZ_SNGL: res_nxt = res_s;
        SZ_DBLE: res_nxt = res_d;
        default: begin
          res_nxt = '0;
          ill_nxt = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      out_valid <= 1'b0;
      illegal   <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= vld_nxt;
      if (in_valid) begin
        illegal <= ill_nxt;
        result  <= res_nxt;
      end
    end
  end

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    in_valid |=> out_valid);
  // R8
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !in_valid |=> (!out_valid && $stable(result)));
  // R2
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (in_valid && size == 2'b00) |=> (illegal && result == '0));
  // R3
  pred_known_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    in_valid |-> !$isunknown(pred[PW-1:0]));
endmodule

// File: tb/fpmin_imm_vec_tb.sv
module fpmin_imm_vec_tb;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 128;

  logic            clk, rst_n, in_valid, imm_one, dn_mode;
  logic [1:0]      size;
  logic [VW-1:0]   src;
  logic [VW/8-1:0] pred;
  logic            out_valid, illegal;
  logic [VW-1:0]   result;

  int n_chk = 0;
  int n_fail = 0;

  fpmin_imm_vec #(.VW(VW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size(size),
    .imm_one(imm_one), .dn_mode(dn_mode), .src(src), .pred(pred),
    .out_valid(out_valid), .illegal(illegal), .result(result));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] sz, input logic im, input logic dn,
                        input logic [VW-1:0] s, input logic [VW/8-1:0] p);
    @(negedge clk);
    size = sz; imm_one = im; dn_mode = dn; src = s; pred = p; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  localparam logic [VW-1:0] HALF_SRC =
    {16'h0001, 16'h7C00, 16'h7C01, 16'h7E01, 16'h8000, 16'h4000, 16'h3800, 16'hBC00};

  task automatic t_reset();
    check("R8 reset out_valid", VW'(out_valid), '0);
    check("R8 reset result", result, '0);
  endtask

  task automatic t_half_one();
    run_op(2'b01, 1'b1, 1'b0, HALF_SRC, '1);
    check("R8 valid after strobe", VW'(out_valid), VW'(1));
    check("R1 R4 R5 R6 R7 half imm1 dn0", result,
      {16'h0001, 16'h3C00, 16'h7E01, 16'h3C00, 16'h8000, 16'h3C00, 16'h3800, 16'hBC00});
  endtask

  task automatic t_half_zero();
    run_op(2'b01, 1'b0, 1'b1, HALF_SRC, '1);
    check("R4 R5 R6 R7 half imm0 dn1", result,
      {16'h0000, 16'h0000, 16'h7E00, 16'h0000, 16'h8000, 16'h0000, 16'h0000, 16'hBC00});
  endtask

  task automatic t_pred();
    run_op(2'b10, 1'b1, 1'b0, {4{32'h40000000}}, 16'h0FE1);
    check("R3 predicate lowest byte", result,
      {32'h40000000, 32'h3F800000, 32'h40000000, 32'h3F800000});
    run_op(2'b01, 1'b1, 1'b0, HALF_SRC, 16'hAAAA);
    check("R3 all lanes inactive", result, HALF_SRC);
  endtask

  task automatic t_single();
    run_op(2'b10, 1'b0, 1'b0,
      {32'hFF800001, 32'h80000000, 32'h00000000, 32'hFF800000}, '1);
    check("R5 R7 single zeros and negative snan", result,
      {32'hFFC00001, 32'h80000000, 32'h00000000, 32'hFF800000});
    run_op(2'b10, 1'b1, 1'b1,
      {32'h3F800000, 32'h7FC00000, 32'h3F800001, 32'hFF800001}, '1);
    check("R4 R6 R7 single imm1 dn1", result,
      {32'h3F800000, 32'h3F800000, 32'h3F800000, 32'h7FC00000});
  endtask

  task automatic t_double();
    run_op(2'b11, 1'b1, 1'b0, {64'h3FF0000000000001, 64'h7FF0000000000001}, '1);
    check("R1 R7 double dn0", result, {64'h3FF0000000000000, 64'h7FF8000000000001});
    run_op(2'b11, 1'b0, 1'b1, {64'h000FFFFFFFFFFFFF, 64'h7FF0000000000001}, '1);
    check("R5 R7 double dn1 subnormal", result, {64'h0000000000000000, 64'h7FF8000000000000});
  endtask

  task automatic t_illegal();
    run_op(2'b00, 1'b1, 1'b0, HALF_SRC, '1);
    check("R2 illegal flag", VW'(illegal), VW'(1));
    check("R2 result zero", result, '0);
    check("R2 valid", VW'(out_valid), VW'(1));
    run_op(2'b01, 1'b1, 1'b0, HALF_SRC, '0);
    check("R2 illegal clears", VW'(illegal), '0);
  endtask

  task automatic t_hold();
    logic [VW-1:0] prev;
    prev = result;
    @(negedge clk);
    src = ~src; size = 2'b10;
    @(negedge clk);
    check("R8 valid low without strobe", VW'(out_valid), '0);
    check("R8 result held", result, prev);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; size = 2'b01; imm_one = 1'b0;
    dn_mode = 1'b0; src = '0; pred = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_half_one();
    t_half_zero();
    t_pred();
    t_single();
    t_double();
    t_illegal();
    t_hold();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule